// File: doc/BRIEF.md
# Interrupt vector ring writer

This block takes interrupt events from on-chip clients and stores each one as a 128-bit vector in a circular buffer held in memory. It owns the write pointer. The host owns the read pointer and programs it through a small register port. Both pointers count bytes and move in steps of 16. The ring holds pending work whenever the two pointers differ, and the block then signals a pending interrupt to the host.

Three optional behaviours are switched by control bits:

- **Overflow flag.** When a write lands the write pointer on the read pointer, the block sets a sticky overflow flag. The flag is reported in the top bit of the write-pointer word.
- **Pointer writeback.** After each vector, the block mirrors the write-pointer word into a memory slot.
- **Rearm.** A new interrupt pulse is raised when a host read-pointer update leaves work outstanding.

Clearing the ring-enable bit parks both pointers at zero. A soft-reset input returns the datapath to idle with empty pointers and leaves the configuration intact.

Top module: `ivring_writer`

## Requirements
- R1: An accepted event causes one 128-bit write with `mem_wide`=1 to address (ring base register value × 256) + write pointer. The data carries source id in [7:0], source data in [59:32], ring id in [71:64], VMID in [79:72] and PASID in [95:80]. Every other bit is zero.
- R2: Each accepted event advances the write pointer by 16 bytes, wrapping modulo 2^(n+2) bytes. Here n is control field [5:1], the log2 of the ring size in 32-bit words. Host pointer writes are masked to the ring size and to 16-byte alignment.
- R3: `irq_pending` is high exactly when control bit 12 (interrupt enable) and bit 0 (ring enable) are set and either the pointers differ or the overflow flag is set. `irq_pulse` is high for one cycle after each accepted event while bit 12 is set.
- R4: If an advance makes the write pointer equal the read pointer, the vector is still written. With control bit 8 (overflow enable) set, bit 31 of the write-pointer word becomes 1 and stays 1 until a control write with bit 9 set. Bit 9 reads back as 0.
- R5: With control bit 10 (writeback enable) set, the cycle after a vector write carries a 32-bit write (`mem_wide`=0) of the updated write-pointer word to the 40-bit address {register 5 [7:0], register 4 [31:2], 2'b00}. `ev_ready` is low during that cycle.
- R6: While ring enable is 0, both pointers and the overflow flag are zero, events are consumed and dropped with no memory write, and host pointer writes have no effect.
- R7: With control bit 11 (rearm) and interrupt enable set, a host write to the read pointer that leaves it unequal to the write pointer produces a one-cycle `irq_pulse`. With rearm clear, it produces none.
- R8: `busy` is high while the pointers differ, the overflow flag is set, or a vector or writeback write is in flight.
- R9: A one-cycle `soft_rst` clears both pointers, the overflow flag and any in-flight write, and keeps every configuration register.
- R10: Register map:

  | Address | Register |
  |---|---|
  | 0 | control |
  | 1 | ring base (address >> 8) |
  | 2 | read pointer |
  | 3 | write-pointer word |
  | 4 | writeback address low |
  | 5 | writeback address high |

  Reads return the value of the selected register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Datapath reset, configuration kept |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event consumed this cycle when valid |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 8 | VMID |
| ev_pasid | input | 16 | PASID |
| mem_we | output | 1 | Memory write strobe |
| mem_wide | output | 1 | 1: 128-bit vector, 0: 32-bit pointer writeback |
| mem_addr | output | 40 | Byte address |
| mem_wdata | output | 128 | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_pending | output | 1 | Unread vectors or overflow present |
| irq_pulse | output | 1 | One-cycle host interrupt |
| busy | output | 1 | Work pending or writing |

## Verification
Results fall due at fixed points after the clock edge that accepts an event:

- the vector write, the new pointer, `irq_pulse`, `irq_pending` and `busy` are visible right after the accepting edge;
- the writeback write is visible one edge later;
- a read-pointer update reports its rearm pulse after the writing edge;
- a ring disable clears the pointers one edge after the control write lands.

The bench drives inputs on the falling edge and samples on the next falling edge after the edge where each result is due. Every register read waits the one extra edge of the registered read path.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_BASE = 3'd1,
    RA_RPTR = 3'd2,
    RA_WPTR = 3'd3,
    RA_WBLO = 3'd4,
    RA_WBHI = 3'd5
  } reg_addr_e;

  // control register bit positions
  localparam int CB_EN     = 0;
  localparam int CB_SZ     = 1;
  localparam int SZ_W      = 5;
  localparam int CB_OVFEN  = 8;
  localparam int CB_OVFCLR = 9;
  localparam int CB_WBEN   = 10;
  localparam int CB_REARM  = 11;
  localparam int CB_IRQEN  = 12;
  localparam int OVF_BIT   = 31;
  localparam int VEC_BYTES = 16;

  typedef struct packed {
    logic            irq_en;
    logic            rearm;
    logic            wb_en;
    logic            ovf_en;
    logic [SZ_W-1:0] size;
    logic            ring_en;
  } cfg_t;

  typedef struct packed {
    logic [7:0]  src;
    logic [27:0] data;
    logic [7:0]  ring;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } event_t;

  function automatic logic [127:0] pack_vec(event_t e);
    logic [127:0] v;
    v          = '0;
    v[7:0]     = e.src;
    v[59:32]   = e.data;
    v[71:64]   = e.ring;
    v[79:72]   = e.vmid;
    v[95:80]   = e.pasid;
    return v;
  endfunction

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [PTR_W-1:0] rptr,
  input  logic [31:0]      wptr_word,
  output cfg_t             cfg,
  output logic [31:0]      base,
  output logic [39:0]      wb_addr,
  output logic             ovf_clr,
  output logic             rptr_wr,
  output logic             wptr_wr,
  output logic [31:0]      rdata
);

  logic [29:0] wb_lo_q;
  logic [7:0]  wb_hi_q;
  logic [31:0] rd_mux;

  assign ovf_clr = we && (addr == RA_CTRL) && wdata[CB_OVFCLR];
  assign rptr_wr = we && (addr == RA_RPTR);
  assign wptr_wr = we && (addr == RA_WPTR);
  assign wb_addr = {wb_hi_q, wb_lo_q, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      base    <= '0;
      wb_lo_q <= '0;
      wb_hi_q <= '0;
    end else if (we) begin
      case (addr)
        RA_CTRL: begin
          cfg.ring_en <= wdata[CB_EN];
          cfg.size    <= wdata[CB_SZ +: SZ_W];
          cfg.ovf_en  <= wdata[CB_OVFEN];
          cfg.wb_en   <= wdata[CB_WBEN];
          cfg.rearm   <= wdata[CB_REARM];
          cfg.irq_en  <= wdata[CB_IRQEN];
        end
        RA_BASE: base    <= wdata;
        RA_WBLO: wb_lo_q <= wdata[31:2];
        RA_WBHI: wb_hi_q <= wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL: begin
        rd_mux[CB_EN]          = cfg.ring_en;
        rd_mux[CB_SZ +: SZ_W]  = cfg.size;
        rd_mux[CB_OVFEN]       = cfg.ovf_en;
        rd_mux[CB_WBEN]        = cfg.wb_en;
        rd_mux[CB_REARM]       = cfg.rearm;
        rd_mux[CB_IRQEN]       = cfg.irq_en;
      end
      RA_BASE: rd_mux = base;
      RA_RPTR: rd_mux[PTR_W-1:0] = rptr;
      RA_WPTR: rd_mux = wptr_word;
      RA_WBLO: rd_mux = {wb_lo_q, 2'b00};
      RA_WBHI: rd_mux[7:0] = wb_hi_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             ring_en,
  input  logic [SZ_W-1:0]  size,
  input  logic             ovf_en,
  input  logic             rearm,
  input  logic             irq_en,
  input  logic             accept,
  input  logic             rptr_wr,
  input  logic             wptr_wr,
  input  logic             ovf_clr,
  input  logic [PTR_W-1:0] wval,
  output logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wptr,
  output logic             ovf,
  output logic             irq_pulse
);

  localparam logic [PTR_W-1:0] STEP  = PTR_W'(VEC_BYTES);
  localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(VEC_BYTES - 1);

  logic [PTR_W-1:0] amask;
  logic [PTR_W-1:0] wptr_nxt;
  logic [PTR_W-1:0] host_val;
  logic             hit;

  // byte mask: ring holds 2^(size+2) bytes, clamped to pointer width
  always_comb begin
    int lg;
    lg = int'(size) + 2;
    if (lg > PTR_W) lg = PTR_W;
    if (lg < 4)     lg = 4;
    for (int i = 0; i < PTR_W; i++) amask[i] = (i < lg);
    amask = amask & ALIGN;
  end

  assign wptr_nxt = (wptr + STEP) & amask;
  assign host_val = wval & amask;
  assign hit      = (wptr_nxt == rptr);

  always_ff @(posedge clk) begin
    if (rst || soft_rst || !ring_en) begin
      rptr      <= '0;
      wptr      <= '0;
      ovf       <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      if (accept) begin
        wptr <= wptr_nxt;
        if (irq_en) irq_pulse <= 1'b1;
      end else if (wptr_wr) begin
        wptr <= host_val;
      end
      if (rptr_wr) begin
        rptr <= host_val;
        if (rearm && irq_en && (host_val != wptr)) irq_pulse <= 1'b1;
      end
      if (accept && hit && ovf_en) ovf <= 1'b1;
      else if (ovf_clr)            ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/ivr_fsm.sv
module ivr_fsm
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ev_valid,
  input  event_t            ev,
  input  logic              ring_en,
  input  logic              wb_en,
  input  logic [31:0]       base,
  input  logic [39:0]       wb_addr,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [31:0]       wptr_word,
  output logic              ev_ready,
  output logic              accept,
  output logic              in_wb,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [127:0]      mem_wdata
);

  typedef enum logic {ST_IDLE, ST_WB} state_e;
  state_e state;

  logic [ADDR_W-1:0] ring_addr;

  assign ring_addr = ADDR_W'({base, 8'h00}) + ADDR_W'(wptr);
  assign ev_ready  = (state == ST_IDLE);
  assign accept    = ev_valid && ev_ready && ring_en && !soft_rst;
  assign in_wb     = (state == ST_WB);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state     <= ST_IDLE;
      mem_we    <= 1'b0;
      mem_wide  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          mem_we    <= 1'b1;
          mem_wide  <= 1'b1;
          mem_addr  <= ring_addr;
          mem_wdata <= pack_vec(ev);
          state     <= wb_en ? ST_WB : ST_IDLE;
        end
        ST_WB: begin
          mem_we    <= 1'b1;
          mem_wide  <= 1'b0;
          mem_addr  <= ADDR_W'(wb_addr);
          mem_wdata <= {96'b0, wptr_word};
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ivring_writer.sv
module ivring_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [7:0]        ev_src,
  input  logic [27:0]       ev_data,
  input  logic [7:0]        ev_ring,
  input  logic [7:0]        ev_vmid,
  input  logic [15:0]       ev_pasid,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [127:0]      mem_wdata,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_pending,
  output logic              irq_pulse,
  output logic              busy
);

  cfg_t             cfg;
  event_t           ev;
  logic [31:0]      base;
  logic [39:0]      wb_addr;
  logic             ovf_clr, rptr_wr, wptr_wr;
  logic [PTR_W-1:0] rptr, wptr;
  logic             ovf;
  logic [31:0]      wptr_word;
  logic             accept, in_wb;

  assign ev = '{src: ev_src, data: ev_data, ring: ev_ring, vmid: ev_vmid, pasid: ev_pasid};

  always_comb begin
    wptr_word              = '0;
    wptr_word[PTR_W-1:0]   = wptr;
    wptr_word[OVF_BIT]     = ovf;
  end

  ivr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rptr(rptr), .wptr_word(wptr_word), .cfg(cfg), .base(base),
    .wb_addr(wb_addr), .ovf_clr(ovf_clr), .rptr_wr(rptr_wr),
    .wptr_wr(wptr_wr), .rdata(reg_rdata)
  );

  ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ring_en(cfg.ring_en),
    .size(cfg.size), .ovf_en(cfg.ovf_en), .rearm(cfg.rearm),
    .irq_en(cfg.irq_en), .accept(accept), .rptr_wr(rptr_wr),
    .wptr_wr(wptr_wr), .ovf_clr(ovf_clr), .wval(reg_wdata[PTR_W-1:0]),
    .rptr(rptr), .wptr(wptr), .ovf(ovf), .irq_pulse(irq_pulse)
  );

  ivr_fsm #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ev_valid(ev_valid), .ev(ev),
    .ring_en(cfg.ring_en), .wb_en(cfg.wb_en), .base(base), .wb_addr(wb_addr),
    .wptr(wptr), .wptr_word(wptr_word), .ev_ready(ev_ready),
    .accept(accept), .in_wb(in_wb), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign irq_pending = cfg.irq_en && cfg.ring_en && ((rptr != wptr) || ovf);
  assign busy        = (rptr != wptr) || ovf || in_wb || mem_we;

endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
  parameter int PTR_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic             accept,
  input logic             ring_en,
  input logic             wb_en,
  input logic             ev_ready,
  input logic             mem_we,
  input logic             mem_wide,
  input logic [59:0]      zero_bits,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] wptr,
  input logic             busy,
  input logic             irq_pending
);

  // R1: reserved vector fields stay zero
  a_r1_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wide) |-> (zero_bits == '0));

  // R2: pointers are always vector aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    (wptr[3:0] == 4'h0) && (rptr[3:0] == 4'h0));

  // R5: writeback follows the vector write, ready drops meanwhile
  a_r5_wb_slot: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (accept && wb_en) |-> ##2 (mem_we && !mem_wide));
  a_r5_ready_low: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (accept && wb_en) |=> !ev_ready);

  // R6: no vector write from an event seen while disabled
  a_r6_drop: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (!ring_en && ev_ready) |=> !(mem_we && mem_wide));

  // R8: busy covers writes in flight and pending work
  a_r8_busy_wr: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  a_r8_busy_irq: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> busy);

  // R9: soft reset empties the ring and stops writes
  a_r9_soft: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> ((wptr == '0) && (rptr == '0) && !mem_we));

endmodule

bind ivring_writer ivr_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .accept(accept),
  .ring_en(cfg.ring_en), .wb_en(cfg.wb_en), .ev_ready(ev_ready),
  .mem_we(mem_we), .mem_wide(mem_wide),
  .zero_bits({mem_wdata[127:96], mem_wdata[63:60], mem_wdata[31:8]}),
  .rptr(rptr), .wptr(wptr), .busy(busy), .irq_pending(irq_pending)
);

// File: tb/test_ivring_writer.sv
`timescale 1ns/1ps
module test_ivring_writer;

  logic         clk = 0;
  logic         rst = 1;
  logic         soft_rst = 0;
  logic         ev_valid = 0;
  logic         ev_ready;
  logic [7:0]   ev_src = 0;
  logic [27:0]  ev_data = 0;
  logic [7:0]   ev_ring = 0;
  logic [7:0]   ev_vmid = 0;
  logic [15:0]  ev_pasid = 0;
  logic         mem_we, mem_wide;
  logic [39:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         reg_we = 0;
  logic [2:0]   reg_addr = 0;
  logic [31:0]  reg_wdata = 0;
  logic [31:0]  reg_rdata;
  logic         irq_pending, irq_pulse, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ivring_writer i_ivring_writer (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring),
    .ev_vmid(ev_vmid), .ev_pasid(ev_pasid), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pending(irq_pending), .irq_pulse(irq_pulse),
    .busy(busy)
  );

  localparam logic [39:0] BASE_B = 40'h12300;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [127:0] act, input logic [127:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [127:0] vec(input logic [7:0] s, input logic [27:0] d,
                                       input logic [7:0] rg, input logic [7:0] vm,
                                       input logic [15:0] pa);
    logic [127:0] v = '0;
    v[7:0] = s; v[59:32] = d; v[71:64] = rg; v[79:72] = vm; v[95:80] = pa;
    return v;
  endfunction

  // drives one event; checks the vector write in the sample slot after the accepting edge
  task automatic send(input logic [7:0] s, input logic [27:0] d, input logic [7:0] rg,
                      input logic [7:0] vm, input logic [15:0] pa,
                      input logic [39:0] exp_addr, input bit exp_wr, input string tag);
    @(negedge clk);
    chk_eq({tag, " ready"}, ev_ready, 1'b1);
    ev_valid = 1; ev_src = s; ev_data = d; ev_ring = rg; ev_vmid = vm; ev_pasid = pa;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0;
    if (exp_wr) begin
      chk_eq({tag, " we"}, {mem_we, mem_wide}, 2'b11);
      chk_eq({tag, " addr"}, mem_addr, exp_addr);
      chk_eq({tag, " data"}, mem_wdata, vec(s, d, rg, vm, pa));
    end else begin
      chk_eq({tag, " no write"}, mem_we, 1'b0);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk_eq("R10 reset ctrl", {ev_ready, busy, irq_pending, mem_we}, 4'b1000);
    rd(3'd0, v); chk_eq("R10 ctrl zero", v, 32'h0);
    rd(3'd3, v); chk_eq("R10 wptr zero", v, 32'h0);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    wr(3'd1, 32'h123);
    wr(3'd0, 32'h1009);          // enable, size 4 (64 bytes), irq enable
    rd(3'd0, v); chk_eq("R10 ctrl readback", v, 32'h1009);
    send(8'hA5, 28'hABCDEF1, 8'h3C, 8'h7E, 16'hBEEF, BASE_B, 1, "R1 first");
    chk_eq("R3 pulse", irq_pulse, 1'b1);
    chk_eq("R3 pending", irq_pending, 1'b1);
    chk_eq("R8 busy", busy, 1'b1);
    rd(3'd3, v); chk_eq("R2 wptr 16", v, 32'h10);
    chk_eq("R3 pulse one cycle", irq_pulse, 1'b0);
    send(8'h5A, 28'h0000003, 8'hC3, 8'h01, 16'h0102, BASE_B + 40'h10, 1, "R1 second");
    rd(3'd3, v); chk_eq("R2 wptr 32", v, 32'h20);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(3'd2, 32'h10);
    wr(3'd3, 32'h30);
    rd(3'd2, v); chk_eq("R2 rptr set", v, 32'h10);
    send(8'h11, 28'h22, 8'h33, 8'h44, 16'h5566, BASE_B + 40'h30, 1, "R2 last slot");
    rd(3'd3, v); chk_eq("R2 wrap to zero", v, 32'h0);
    wr(3'd2, 32'h7F);            // masked to 64 bytes, aligned: 0x30
    rd(3'd2, v); chk_eq("R2 host mask", v, 32'h30);
    wr(3'd2, 32'h10);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(3'd0, 32'h1109);          // add overflow enable
    send(8'h01, 28'h1, 8'h0, 8'h0, 16'h0, BASE_B, 1, "R4 hit");
    rd(3'd3, v); chk_eq("R4 ovf set", v, 32'h8000_0010);
    chk_eq("R3 pending on ovf", irq_pending, 1'b1);
    send(8'h02, 28'h2, 8'h0, 8'h0, 16'h0, BASE_B + 40'h10, 1, "R4 still writes");
    rd(3'd3, v); chk_eq("R4 sticky", v, 32'h8000_0020);
    wr(3'd0, 32'h1309);
    rd(3'd3, v); chk_eq("R4 cleared", v, 32'h20);
    rd(3'd0, v); chk_eq("R4 clr reads 0", v, 32'h1109);
  endtask

  task automatic t_writeback();
    logic [31:0] v;
    wr(3'd4, 32'hCAFE_0013);
    wr(3'd5, 32'h5A);
    rd(3'd4, v); chk_eq("R5 lo aligned", v, 32'hCAFE_0010);
    wr(3'd0, 32'h1509);
    send(8'h77, 28'h7, 8'h0, 8'h0, 16'h0, BASE_B + 40'h20, 1, "R5 vector");
    chk_eq("R5 ready low", ev_ready, 1'b0);
    @(negedge clk);
    chk_eq("R5 wb strobe", {mem_we, mem_wide}, 2'b10);
    chk_eq("R5 wb addr", mem_addr, 40'h5A_CAFE_0010);
    chk_eq("R5 wb data", mem_wdata, 128'h30);
    chk_eq("R5 ready back", ev_ready, 1'b1);
  endtask

  task automatic t_rearm();
    wr(3'd0, 32'h1909);          // rearm on, writeback off
    wr(3'd2, 32'h10);
    chk_eq("R7 rearm pulse", irq_pulse, 1'b1);
    wr(3'd2, 32'h30);
    chk_eq("R7 no pulse when equal", irq_pulse, 1'b0);
    chk_eq("R3 idle not pending", irq_pending, 1'b0);
    chk_eq("R8 idle not busy", busy, 1'b0);
    wr(3'd0, 32'h1109);
    wr(3'd2, 32'h20);
    chk_eq("R7 rearm off", irq_pulse, 1'b0);
    chk_eq("R3 pending again", irq_pending, 1'b1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(3'd0, 32'h0008);
    @(negedge clk);
    rd(3'd2, v); chk_eq("R6 rptr zero", v, 32'h0);
    rd(3'd3, v); chk_eq("R6 wptr zero", v, 32'h0);
    send(8'h99, 28'h9, 8'h0, 8'h0, 16'h0, 40'h0, 0, "R6 drop");
    wr(3'd2, 32'h20);
    rd(3'd2, v); chk_eq("R6 host write ignored", v, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(3'd0, 32'h1009);
    send(8'h42, 28'h42, 8'h0, 8'h0, 16'h0, BASE_B, 1, "R9 pre");
    chk_eq("R9 busy before", busy, 1'b1);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    chk_eq("R9 idle", busy, 1'b0);
    rd(3'd3, v); chk_eq("R9 wptr cleared", v, 32'h0);
    rd(3'd0, v); chk_eq("R9 cfg kept", v, 32'h1009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_vector();
    t_wrap();
    t_overflow();
    t_writeback();
    t_rearm();
    t_disable();
    t_soft();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule